// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in a transmit path and fills in IP checksums for outgoing Ethernet frames. A frame enters as a byte stream together with a two-bit offload code. Each byte is written into an internal frame buffer. While the bytes arrive, the block parses the Ethernet and IPv4 headers and keeps running ones-complement sums.

When the last byte has arrived, the block spends one cycle forming the final checksums. It then replays the buffered frame on its output. Where the offload code calls for it, the IPv4 header checksum and the TCP or UDP checksum are overwritten on the way out. While a frame is being replayed, the input is held off through `in_ready`.

The offload code has four levels:
- Off: the frame is not changed.
- Header only: only the IPv4 header checksum is written.
- Header plus transport, seeded: the transport checksum is written, and the value software left in the transport checksum field is taken as a precomputed pseudo-header sum.
- Full: the transport checksum is written, and the hardware adds the pseudo-header itself.

Frames are at most `DEPTH` bytes long. Bytes beyond that limit are not stored.

Top module: `csum_tx_insert`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` falls in the cycle after the last input byte is accepted, stays 0 while output bytes are presented, and returns to 1 once the byte marked `out_last` has gone.
- R2: The first output byte appears two cycles after the clock edge that accepts the last input byte. Output bytes follow on consecutive cycles, their count equals the input frame length, and `out_last` marks only the final byte.
- R3: With code 0 (binary 00) every output byte equals the input byte.
- R4: With code 1 (binary 01) on an eligible frame, frame bytes 24 (high byte) and 25 (low byte) become the inverted ones-complement sum of the IPv4 header's 16-bit words, with that field counted as zero. The transport header and payload are unchanged.
- R5: With code 2 (binary 10) on an eligible frame, R4 applies. In addition, the transport checksum field becomes the inverted ones-complement sum of all transport words, and the field's existing content is included in that sum as a seed.
- R6: With code 3 (binary 11) on an eligible frame, R4 applies. In addition, the transport checksum becomes the inverted ones-complement sum of the transport words plus the pseudo-header: source address, destination address, protocol number, and transport length. The field itself is counted as zero, and the transport length equals total length minus 4×IHL.
- R7: The transport header starts at byte 14 + 4×IHL, so IPv4 options are honoured. The transport checksum field is at offset 16 from that start for TCP (protocol 6) and at offset 6 for UDP (protocol 17). Every checksum field is written high byte first.
- R8: A transport section of odd length is summed as if one zero byte followed it. That byte is not emitted.
- R9: A frame is eligible only if all of the following hold: bytes 12–13 are 0x0800; the high nibble of byte 14 is 4; IHL (the low nibble of byte 14) is at least 5; the protocol in byte 23 is 6 or 17; the total length in bytes 16–17 covers the headers; and 14 + total length does not exceed the frame length. Any frame that is not eligible leaves unchanged under every code.
- R10: Bytes after the end of the IPv4 datagram (Ethernet padding) are passed through unchanged and are left out of all sums.
- R11: The offload code is sampled only with the first byte of a frame. Values on `in_code` during the other bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_code | input | 2 | Offload code, sampled on the first byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Output byte is the last of its frame |

## Verification
The bench goes after the transport field location in several ways: TCP against UDP, a header with an option word, and odd transport lengths. A design that hard-wired a 20-byte header, or that padded an odd section on the wrong side, would place or compute the checksum wrongly.

Other frames must stay unchanged under full offload: one that is not IPv4, one with a bad version, one with an unsupported protocol, and one that claims more bytes than it carries. A design that skipped any eligibility test would corrupt such a frame.

The seeded and full codes are run side by side with a deliberately non-zero field value. Zeroing the seed would break code 2, and keeping it would break code 3. Frames with trailing padding catch a design that sums past the datagram. Because `in_code` is inverted after the first byte of every frame, late sampling of the code shows up at once.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef logic [16:0] pos_t;

  localparam pos_t ETH_LEN   = 17'd14;
  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;

  typedef enum logic [1:0] {
    CODE_OFF    = 2'b00,
    CODE_HDR    = 2'b01,
    CODE_SEEDED = 2'b10,
    CODE_FULL   = 2'b11
  } offload_e;

  typedef enum logic [1:0] {ST_RECV, ST_FINAL, ST_SEND} phase_e;

  // Place a byte in its half of a 16-bit word, widened for accumulation.
  function automatic logic [31:0] word_of(input logic [7:0] b, input logic low_half);
    return low_half ? {24'h0, b} : {16'h0, b, 8'h00};
  endfunction

  // Ones-complement fold of a wide sum down to 16 bits.
  function automatic logic [15:0] ones_fold(input logic [31:0] s);
    logic [16:0] t;
    t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    return t[15:0] + {15'h0, t[16]};
  endfunction
endpackage

// File: rtl/csum_rx_parse.sv
module csum_rx_parse
  import csum_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    din,
  input  logic [1:0]    code_in,
  output logic [1:0]    code_q,
  output logic [15:0]   etype_q,
  output logic [3:0]    ver_q,
  output logic [3:0]    ihl_q,
  output logic [15:0]   tot_q,
  output logic [7:0]    proto_q,
  output logic [31:0]   hsum_q,
  output logic [31:0]   lsum_q,
  output pos_t          l4_pos
);
  pos_t i17, hdr_end, ip_end;
  logic first, in_hdr, in_l4, hck, lck, pseudo;
  logic [31:0] word, h_add, l_add;

  assign i17     = pos_t'(idx);
  assign first   = (idx == '0);
  assign hdr_end = ETH_LEN + pos_t'({ihl_q, 2'b00});
  assign ip_end  = ETH_LEN + pos_t'(tot_q);
  assign l4_pos  = hdr_end + ((proto_q == PROTO_TCP) ? pos_t'(16) : pos_t'(6));

  assign in_hdr = (i17 >= ETH_LEN) && ((i17 < ETH_LEN + pos_t'(20)) || (i17 < hdr_end));
  assign in_l4  = (i17 >= ETH_LEN + pos_t'(20)) && (i17 >= hdr_end) && (i17 < ip_end);
  assign hck    = (i17 == ETH_LEN + pos_t'(10)) || (i17 == ETH_LEN + pos_t'(11));
  assign lck    = (i17 == l4_pos) || (i17 == l4_pos + pos_t'(1));
  assign pseudo = (code_q == CODE_FULL) && (i17 >= ETH_LEN + pos_t'(12)) &&
                  (i17 < ETH_LEN + pos_t'(20));

  assign word  = word_of(din, i17[0] ^ ETH_LEN[0]);
  assign h_add = (in_hdr && !hck) ? word : 32'h0;
  // Seeded mode keeps the field in the sum; other modes count it as zero.
  assign l_add = ((in_l4 && !(lck && code_q != CODE_SEEDED)) || pseudo) ? word : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= CODE_OFF;
      etype_q <= '0;
      ver_q   <= '0;
      ihl_q   <= '0;
      tot_q   <= '0;
      proto_q <= '0;
      hsum_q  <= '0;
      lsum_q  <= '0;
    end else if (take) begin
      if (first) begin
        code_q  <= code_in;
        etype_q <= '0;
        ver_q   <= '0;
        ihl_q   <= '0;
        tot_q   <= '0;
        proto_q <= '0;
        hsum_q  <= '0;
        lsum_q  <= '0;
      end else begin
        hsum_q <= hsum_q + h_add;
        lsum_q <= lsum_q + l_add;
        if (i17 == ETH_LEN - pos_t'(2)) etype_q[15:8] <= din;
        if (i17 == ETH_LEN - pos_t'(1)) etype_q[7:0]  <= din;
        if (i17 == ETH_LEN) begin
          ver_q <= din[7:4];
          ihl_q <= din[3:0];
        end
        if (i17 == ETH_LEN + pos_t'(2)) tot_q[15:8] <= din;
        if (i17 == ETH_LEN + pos_t'(3)) tot_q[7:0]  <= din;
        if (i17 == ETH_LEN + pos_t'(9)) proto_q     <= din;
      end
    end
  end
endmodule

// File: rtl/csum_result.sv
module csum_result
  import csum_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic [1:0]    code,
  input  logic [15:0]   etype,
  input  logic [3:0]    ver,
  input  logic [3:0]    ihl,
  input  logic [15:0]   tot,
  input  logic [7:0]    proto,
  input  logic [31:0]   hsum,
  input  logic [31:0]   lsum,
  input  logic [IW-1:0] flen,
  output logic          hdr_en,
  output logic          l4_en,
  output logic [15:0]   ip_ck,
  output logic [15:0]   l4_ck
);
  logic [15:0] hl16, l4len, min_l4;
  logic [31:0] pseudo_add;
  logic        known_proto, elig;

  assign hl16        = {10'h0, ihl, 2'b00};
  assign l4len       = tot - hl16;
  assign known_proto = (proto == PROTO_TCP) || (proto == PROTO_UDP);
  assign min_l4      = (proto == PROTO_TCP) ? 16'd20 : 16'd8;
  assign elig = (etype == 16'h0800) && (ver == 4'd4) && (ihl >= 4'd5) && known_proto &&
                (tot >= hl16 + min_l4) && (ETH_LEN + pos_t'(tot) <= pos_t'(flen));

  assign pseudo_add = (code == CODE_FULL) ? ({24'h0, proto} + {16'h0, l4len}) : 32'h0;
  assign ip_ck      = ~ones_fold(hsum);
  assign l4_ck      = ~ones_fold(lsum + pseudo_add);
  assign hdr_en     = elig && (code != CODE_OFF);
  assign l4_en      = elig && code[1];
endmodule

// File: rtl/csum_tx_stream.sv
module csum_tx_stream
  import csum_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] rd_idx,
  input  logic          hdr_en,
  input  logic          l4_en,
  input  logic [15:0]   ip_ck,
  input  logic [15:0]   l4_ck,
  input  pos_t          l4_pos,
  output logic [7:0]    byte_out,
  output logic          sub
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [7:0] raw;
  pos_t       p;
  logic       ip_hi, ip_lo, l4_hi, l4_lo;

  always_ff @(posedge clk) begin
    if (we) mem[waddr[AW-1:0]] <= wdata;
  end

  assign raw   = mem[rd_idx[AW-1:0]];
  assign p     = pos_t'(rd_idx);
  assign ip_hi = hdr_en && (p == ETH_LEN + pos_t'(10));
  assign ip_lo = hdr_en && (p == ETH_LEN + pos_t'(11));
  assign l4_hi = l4_en && (p == l4_pos);
  assign l4_lo = l4_en && (p == l4_pos + pos_t'(1));
  assign sub   = ip_hi || ip_lo || l4_hi || l4_lo;

  always_comb begin
    byte_out = raw;
    if (ip_hi) byte_out = ip_ck[15:8];
    if (ip_lo) byte_out = ip_ck[7:0];
    if (l4_hi) byte_out = l4_ck[15:8];
    if (l4_lo) byte_out = l4_ck[7:0];
  end
endmodule

// File: rtl/csum_tx_insert.sv
module csum_tx_insert
  import csum_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic [1:0] in_code,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  phase_e        state;
  logic [IW-1:0] wr_cnt, len_q, rd_idx;
  logic          take, we;

  logic [1:0]  code_q;
  logic [15:0] etype_q, tot_q;
  logic [3:0]  ver_q, ihl_q;
  logic [7:0]  proto_q;
  logic [31:0] hsum_q, lsum_q;
  pos_t        l4_pos;

  logic        hdr_en_c, l4_en_c, hdr_en_q, l4_en_q;
  logic [15:0] ip_ck_c, l4_ck_c, ip_ck_q, l4_ck_q;
  logic        tx_sub;

  assign in_ready = (state == ST_RECV);
  assign take     = in_valid && in_ready;
  assign we       = take && (wr_cnt < DEPTH_W);

  csum_rx_parse #(.IW(IW)) u_parse (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(wr_cnt), .din(in_data),
    .code_in(in_code), .code_q(code_q), .etype_q(etype_q), .ver_q(ver_q),
    .ihl_q(ihl_q), .tot_q(tot_q), .proto_q(proto_q), .hsum_q(hsum_q),
    .lsum_q(lsum_q), .l4_pos(l4_pos)
  );

  csum_result #(.IW(IW)) u_result (
    .code(code_q), .etype(etype_q), .ver(ver_q), .ihl(ihl_q), .tot(tot_q),
    .proto(proto_q), .hsum(hsum_q), .lsum(lsum_q), .flen(len_q),
    .hdr_en(hdr_en_c), .l4_en(l4_en_c), .ip_ck(ip_ck_c), .l4_ck(l4_ck_c)
  );

  csum_tx_stream #(.DEPTH(DEPTH), .IW(IW)) u_stream (
    .clk(clk), .we(we), .waddr(wr_cnt), .wdata(in_data), .rd_idx(rd_idx),
    .hdr_en(hdr_en_q), .l4_en(l4_en_q), .ip_ck(ip_ck_q), .l4_ck(l4_ck_q),
    .l4_pos(l4_pos), .byte_out(out_data), .sub(tx_sub)
  );

  assign out_valid = (state == ST_SEND);
  assign out_last  = out_valid && (rd_idx == len_q - IW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_RECV;
      wr_cnt   <= '0;
      len_q    <= '0;
      rd_idx   <= '0;
      hdr_en_q <= 1'b0;
      l4_en_q  <= 1'b0;
      ip_ck_q  <= '0;
      l4_ck_q  <= '0;
    end else begin
      case (state)
        ST_RECV: if (take) begin
          if (in_last) begin
            len_q  <= we ? wr_cnt + IW'(1) : wr_cnt;
            wr_cnt <= '0;
            state  <= ST_FINAL;
          end else if (we) begin
            wr_cnt <= wr_cnt + IW'(1);
          end
        end
        ST_FINAL: begin
          hdr_en_q <= hdr_en_c;
          l4_en_q  <= l4_en_c;
          ip_ck_q  <= ip_ck_c;
          l4_ck_q  <= l4_ck_c;
          rd_idx   <= '0;
          state    <= ST_SEND;
        end
        default: begin
          if (out_last) state <= ST_RECV;
          rd_idx <= rd_idx + IW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/csum_tx_insert_chk.sv
module csum_tx_insert_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_last,
  input logic          tx_sub,
  input logic [1:0]    code_q,
  input logic [IW-1:0] rd_idx
);
  logic last_take;
  assign last_take = in_valid && in_ready && in_last;

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !in_ready); // R1
  AST_START_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> ##1 out_valid); // R2
  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid); // R2
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R2
  AST_OFF_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && code_q == 2'b00) |-> !tx_sub); // R3
  AST_HDR_ONLY_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tx_sub && code_q == 2'b01) |-> (rd_idx == IW'(24) || rd_idx == IW'(25))); // R4
endmodule

bind csum_tx_insert csum_tx_insert_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_last(out_last),
  .tx_sub(tx_sub), .code_q(code_q), .rd_idx(rd_idx)
);

// File: tb/tb_csum_tx_insert.sv
`timescale 1ns/1ps
module tb_csum_tx_insert;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_code = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  csum_tx_insert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_code(in_code),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, fails = 0;
  logic [7:0] frm [256];
  logic [7:0] expd [256];
  logic [7:0] got [256];
  int flen;

  // kind[15:12]: 0 UDP, 1 TCP, 2 ICMP, 3 non-IPv4 ethertype, 4 UDP with option word,
  // 5 UDP with trailing pad, 6 bad version, 7 length overrun; code[9:8]; payload[7:0]
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'h0009, 16'h010A, 16'h020B, 16'h030C,  // UDP all codes, odd (R8) included
    16'h1106, 16'h1207, 16'h1321,            // TCP (R7), odd payload (R8)
    16'h4305,                                // IHL 6 (R7)
    16'h2308, 16'h3308,                      // R9
    16'h5304,                                // R10
    16'h6308, 16'h7308,                      // R9
    16'h1300, 16'h0200
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fold_tb(input logic [31:0] s);
    logic [31:0] t = s;
    while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

  task automatic build(input int kind, input logic [1:0] code, input int pay, input int vi);
    bit tcp = (kind == 1);
    int ihl = (kind == 4) ? 6 : 5;
    int hl = ihl * 4;
    int l4h = tcp ? 20 : 8;
    int l4len = l4h + pay;
    int tot = hl + l4len;
    int totf = (kind == 7) ? tot + 4 : tot;
    int b = 14 + hl;
    int off = tcp ? 16 : 6;
    logic [15:0] seed = 16'h5A3C + 16'(vi * 257);
    logic [31:0] s;
    logic [7:0] proto = tcp ? 8'd6 : ((kind == 2) ? 8'd1 : 8'd17);
    flen = 14 + tot + ((kind == 5) ? 6 : 0);
    for (int i = 0; i < 256; i++) frm[i] = 8'hEE;
    for (int i = 0; i < 12; i++) frm[i] = 8'(8'hA0 + i);
    frm[12] = (kind == 3) ? 8'h86 : 8'h08;
    frm[13] = (kind == 3) ? 8'hDD : 8'h00;
    frm[14] = {(kind == 6) ? 4'h5 : 4'h4, 4'(ihl)};
    frm[15] = 0; frm[16] = 8'(totf >> 8); frm[17] = 8'(totf);
    frm[18] = 8'h12; frm[19] = 8'(8'h34 ^ vi); frm[20] = 0; frm[21] = 0;
    frm[22] = 64; frm[23] = proto; frm[24] = 8'hAB; frm[25] = 8'hCD;
    frm[26] = 10; frm[27] = 0; frm[28] = 0; frm[29] = 1;
    frm[30] = 192; frm[31] = 168; frm[32] = 8'(vi); frm[33] = 7;
    if (ihl == 6) for (int i = 34; i < 38; i++) frm[i] = 8'h01;
    for (int j = 0; j < l4h; j++) frm[b + j] = 8'(8'h11 * j);
    frm[b] = 8'h04; frm[b + 1] = 8'(8'hD2 + vi); frm[b + 2] = 0; frm[b + 3] = 8'h35;
    if (!tcp) begin frm[b + 4] = 8'(l4len >> 8); frm[b + 5] = 8'(l4len); end
    frm[b + off] = seed[15:8]; frm[b + off + 1] = seed[7:0];
    for (int j = 0; j < pay; j++) frm[b + l4h + j] = 8'(j * 7 + vi * 13 + 3);
    for (int i = 0; i < 256; i++) expd[i] = frm[i];
    if (kind <= 1 || kind == 4 || kind == 5) begin
      if (code != 2'b00) begin
        s = 0;
        for (int w = 0; w < hl / 2; w++)
          if (w != 5) s += {16'h0, frm[14 + 2 * w], frm[15 + 2 * w]};
        s = {16'h0, ~fold_tb(s)};
        expd[24] = s[15:8]; expd[25] = s[7:0];
      end
      if (code[1]) begin
        s = 0;
        for (int j = 0; j < l4len; j += 2)
          if (!(code == 2'b11 && j == off))
            s += {16'h0, frm[b + j], (j + 1 < l4len) ? frm[b + j + 1] : 8'h00};
        if (code == 2'b11) begin
          for (int k = 26; k < 34; k += 2) s += {16'h0, frm[k], frm[k + 1]};
          s += 32'(proto) + 32'(l4len);
        end
        s = {16'h0, ~fold_tb(s)};
        expd[b + off] = s[15:8]; expd[b + off + 1] = s[7:0];
      end
    end
  endtask

  function automatic string req_of(input int kind, input logic [1:0] code);
    if (kind == 2 || kind == 3 || kind == 6 || kind == 7) return "R9";
    if (kind == 5) return "R10";
    if (kind == 4 || kind == 1) return "R7";
    case (code)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_frame(input logic [1:0] code, input string req);
    int n = 0, bad = 0, badi = -1;
    bit lat_ok, busy_ok = 1, last_ok = 0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < flen; i++) begin
      in_valid = 1; in_data = frm[i]; in_last = (i == flen - 1);
      in_code = (i == 0) ? code : ~code;  // R11: later values must be ignored
      @(posedge clk);
      if (i != flen - 1) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    lat_ok = !out_valid;
    @(negedge clk);
    lat_ok = lat_ok && out_valid;
    while (out_valid && n < 256) begin
      got[n] = out_data;
      if (in_ready) busy_ok = 0;
      n++;
      if (out_last) begin last_ok = 1; break; end
      @(negedge clk);
    end
    for (int i = 0; i < n && i < flen; i++)
      if (got[i] !== expd[i]) begin bad++; if (badi < 0) badi = i; end
    check(lat_ok, "R2", "start two cycles after last input", int'(out_valid), 1);
    check(last_ok && n == flen, "R2", "output length", n, flen);
    check(busy_ok, "R1", "in_ready low while sending", 1, 0);
    check(bad == 0, req, "byte mismatch count (first index shown as actual)",
          badi, (badi < 0) ? -1 : int'(expd[badi]));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired: actual hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    for (int v = 0; v < NV; v++) begin
      build(int'(VEC[v][15:12]), VEC[v][9:8], int'(VEC[v][7:0]), v);
      run_frame(VEC[v][9:8], req_of(int'(VEC[v][15:12]), VEC[v][9:8]));
    end

    // R1: reset in mid-frame returns the block to idle, then a frame still works
    build(0, 2'b11, 6, 20);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      in_valid = 1; in_data = frm[i]; in_last = 0; in_code = 2'b11;
      @(negedge clk);
    end
    in_valid = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "idle after mid-frame reset",
          int'({in_ready, out_valid}), 2);
    run_frame(2'b11, "R6");

    // R11: off code on the first byte, full code on the others
    build(1, 2'b00, 5, 21);
    run_frame(2'b00, "R11");
    finish_run();
  end
endmodule